// File: doc/BRIEF.md
# TDM PCM Time-Slot Port

This block places one 8-bit PCM sample per frame onto a shared serial time-division bus and takes one sample off it. The block clock is the bus bit clock. Transmit and receive each have their own frame sync, so the two directions can run with any skew between them. Transmit data can go out on either of two data lines, each with its own output enable and its own active-low backplane driver enable. Receive data is taken from either of two input lines.

Two timing modes are supported. In the immediate mode the slot opens with the frame sync, and the slot number is not used. In the counted mode the frame sync marks bit zero of the frame, and a position counter opens the slot a programmed number of bytes later. Each direction has an assignment byte that holds an enable bit, a line select and a 6-bit slot number.

The transmit byte and the received byte move over parallel ports. The received byte comes with a one-cycle valid strobe. A power-down input stops both directions. After power-up, transmit stays silent until the second transmit frame sync.

Top module: `pcm_tdm_port`

## Requirements
- R1: While reset is held and right after it, `tx_oe` is 00, `tx_dat` is 00, `tx_slot_n` is 11 and `rx_vld` is 0. The block comes out of reset in immediate mode.
- R2: After `pdn` goes low, no transmit slot opens in the frame started by the first transmit frame sync. Transmission is allowed from the frame started by the second sync onward.
- R3: With `dly_mode`=0, each slot opens at frame bit 0 whatever the slot number. Frame bit 0 is driven after the first rising edge that follows the falling edge at which the sync is first seen high.
- R4: With `dly_mode`=1, a slot opens at frame bit 8*N, where N is bits [5:0] of the assignment byte and bit 5 is the MSB (N is 0 to 63).
- R5: Assignment bit 7 is the enable. When it is 0, that direction opens no slot on either line: `tx_oe` stays 00 for transmit, and `rx_vld` never rises for receive.
- R6: Assignment bit 6 selects the line (0 or 1). During a transmit slot only the selected `tx_oe` bit is 1, and `tx_dat` on that line carries the byte MSB first for 8 bit periods, changing on rising edges. A line that is not enabled has `tx_dat` low.
- R7: The transmit byte is taken from `tx_byte` on the rising edge that opens the slot. Later changes to `tx_byte` do not alter the bits sent.
- R8: The selected `tx_slot_n` bit is low from the slot start until the falling edge inside the eighth bit, which is 7.5 bit periods. At all other times it is high.
- R9: In a receive slot, the selected `rx_din` line is sampled MSB first on 8 falling edges. The other line, and all bits outside the slot, have no effect on `rx_byte`.
- R10: `rx_vld` is high for exactly one cycle, on frame bit 8*N+8 of the receive frame, and `rx_byte` then holds the received byte.
- R11: Only a low-to-high transition of a frame sync starts a frame, so a sync held high for several bit periods starts one frame. The transmit and receive frames are timed independently.
- R12: `pdn` high ends an open transmit slot from the next cycle on (`tx_oe`=00), stops reception so no `rx_vld` is produced, and restarts the power-up wait of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn | input | 1 | Power-down, 1 = down |
| dly_mode | input | 1 | 0 = immediate slot at sync, 1 = counted slot |
| tx_cfg | input | 8 | Transmit assignment: [7] enable, [6] line, [5:0] slot |
| rx_cfg | input | 8 | Receive assignment: [7] enable, [6] line, [5:0] slot |
| fsx | input | 1 | Transmit frame sync |
| fsr | input | 1 | Receive frame sync |
| tx_byte | input | 8 | Byte to transmit |
| rx_din | input | 2 | Serial receive data lines |
| tx_dat | output | 2 | Serial transmit data per line |
| tx_oe | output | 2 | Tri-state enable per transmit line |
| tx_slot_n | output | 2 | Active-low backplane driver enable per line |
| rx_byte | output | 8 | Last received byte |
| rx_vld | output | 1 | One-cycle strobe for a new `rx_byte` |

## Verification
The bench goes after the power-up wait. A design that counts the first sync as enough, or never arms, transmits one frame early or stays silent. Slot 63 and slot 33 test the MSB of the slot field, which a truncated compare would place at the wrong byte. Changing `tx_byte` right after slot start and putting noise on the unselected receive line expose late capture and crossed line selects. The driver enable is sampled on both sides of the falling edge in bit eight, so a release a half bit early or late is seen. Long sync pulses and transmit/receive skew show whether a level is being taken as a frame start.

// File: rtl/pcm_tdm_pkg.sv
`timescale 1ns/1ps
package pcm_tdm_pkg;
  localparam int SLOT_W     = 6;
  localparam int BYTE_W     = 8;
  localparam int LINES      = 2;
  localparam int FRAME_BITS = (1 << SLOT_W) * BYTE_W;
  localparam int POS_W      = $clog2(FRAME_BITS + 1);
  localparam int IDX_W      = $clog2(BYTE_W);

  typedef struct packed {
    logic              en;
    logic              line;
    logic [SLOT_W-1:0] slot;
  } slot_cfg_t;

  // Frame bit where the slot opens; the counted mode only uses the number
  function automatic int unsigned slot_origin(slot_cfg_t c, logic counted);
    return counted ? int'(c.slot) * BYTE_W : 0;
  endfunction
endpackage

// File: rtl/pcm_fs_edge.sv
`timescale 1ns/1ps
module pcm_fs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic fs,
  output logic mark
);
  logic fs_fall;
  logic fs_rise;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fs_fall <= 1'b0;
    else        fs_fall <= fs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fs_rise <= 1'b0;
    else        fs_rise <= fs_fall;
  end

  assign mark = fs_fall & ~fs_rise;
endmodule

// File: rtl/pcm_slot_timer.sv
`timescale 1ns/1ps
module pcm_slot_timer
  import pcm_tdm_pkg::*;
#(
  parameter int PW    = POS_W,
  parameter int LIMIT = FRAME_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mark,
  input  logic          arm,
  input  logic [PW-1:0] origin,
  output logic          start
);
  localparam logic [PW-1:0] LIM = PW'(LIMIT);
  logic [PW-1:0] pos_q;
  logic [PW-1:0] cur;

  assign cur   = mark ? '0 : pos_q;
  assign start = arm & (cur == origin) & (cur != LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pos_q <= LIM;
    else if (cur == LIM) pos_q <= LIM;
    else                 pos_q <= cur + 1'b1;
  end
endmodule

// File: rtl/pcm_tx_slot.sv
`timescale 1ns/1ps
module pcm_tx_slot
  import pcm_tdm_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int IW = IDX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         kill,
  input  logic [W-1:0] byte_in,
  input  logic         line_in,
  output logic         act,
  output logic         line_q,
  output logic         dout,
  output logic         half_rel
);
  logic [W-1:0]  sh;
  logic [IW-1:0] idx;
  logic          last;

  assign last = (idx == IW'(W - 1));
  assign dout = sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; sh <= '0; idx <= '0; line_q <= 1'b0;
    end else if (kill) begin
      act <= 1'b0;
    end else if (start) begin
      act <= 1'b1; sh <= byte_in; idx <= '0; line_q <= line_in;
    end else if (act) begin
      sh  <= sh << 1;
      idx <= idx + 1'b1;
      if (last) act <= 1'b0;
    end
  end

  // Driver enable is released half way through the last bit
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) half_rel <= 1'b0;
    else        half_rel <= act & last;
  end
endmodule

// File: rtl/pcm_rx_slot.sv
`timescale 1ns/1ps
module pcm_rx_slot
  import pcm_tdm_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int IW = IDX_W,
  parameter int NL = LINES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          kill,
  input  logic          line_in,
  input  logic [NL-1:0] din,
  output logic          act,
  output logic [W-1:0]  byte_out,
  output logic          vld
);
  logic [W-1:0]  sh;
  logic [IW-1:0] idx;
  logic          line_q;
  logic          last;

  assign last = (idx == IW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; idx <= '0; line_q <= 1'b0; byte_out <= '0; vld <= 1'b0;
    end else if (kill) begin
      act <= 1'b0; vld <= 1'b0;
    end else begin
      vld <= act & last;
      if (act & last) byte_out <= sh;
      if (start) begin
        act <= 1'b1; idx <= '0; line_q <= line_in;
      end else if (act) begin
        idx <= idx + 1'b1;
        if (last) act <= 1'b0;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)   sh <= '0;
    else if (act) sh <= {sh[W-2:0], din[line_q]};
  end
endmodule

// File: rtl/pcm_tdm_port.sv
`timescale 1ns/1ps
module pcm_tdm_port
  import pcm_tdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn,
  input  logic              dly_mode,
  input  logic [7:0]        tx_cfg,
  input  logic [7:0]        rx_cfg,
  input  logic              fsx,
  input  logic              fsr,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic [LINES-1:0]  rx_din,
  output logic [LINES-1:0]  tx_dat,
  output logic [LINES-1:0]  tx_oe,
  output logic [LINES-1:0]  tx_slot_n,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_vld
);
  slot_cfg_t   txc, rxc;
  logic        fsx_mark, fsr_mark;
  logic        tx_start, rx_start;
  logic        tx_act, rx_act;
  logic        tx_ready;
  logic        tx_line, tx_dout, tx_half;
  logic [1:0]  up_cnt, up_nxt;
  logic [POS_W-1:0] tx_origin, rx_origin;

  assign txc       = slot_cfg_t'(tx_cfg);
  assign rxc       = slot_cfg_t'(rx_cfg);
  assign tx_origin = POS_W'(slot_origin(txc, dly_mode));
  assign rx_origin = POS_W'(slot_origin(rxc, dly_mode));

  pcm_fs_edge u_fsx (.clk(clk), .rst_n(rst_n), .fs(fsx), .mark(fsx_mark));
  pcm_fs_edge u_fsr (.clk(clk), .rst_n(rst_n), .fs(fsr), .mark(fsr_mark));

  // Power-up wait: the frame of the second transmit sync is the first one sent
  assign up_nxt   = pdn ? 2'd0 :
                    (fsx_mark && up_cnt != 2'd2) ? up_cnt + 2'd1 : up_cnt;
  assign tx_ready = (up_nxt == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= 2'd0;
    else        up_cnt <= up_nxt;
  end

  pcm_slot_timer u_tx_tmr (
    .clk(clk), .rst_n(rst_n), .mark(fsx_mark),
    .arm(txc.en & tx_ready & ~pdn), .origin(tx_origin), .start(tx_start)
  );

  pcm_slot_timer u_rx_tmr (
    .clk(clk), .rst_n(rst_n), .mark(fsr_mark),
    .arm(rxc.en & ~pdn), .origin(rx_origin), .start(rx_start)
  );

  pcm_tx_slot u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .kill(pdn),
    .byte_in(tx_byte), .line_in(txc.line), .act(tx_act),
    .line_q(tx_line), .dout(tx_dout), .half_rel(tx_half)
  );

  pcm_rx_slot u_rx (
    .clk(clk), .rst_n(rst_n), .start(rx_start), .kill(pdn),
    .line_in(rxc.line), .din(rx_din), .act(rx_act),
    .byte_out(rx_byte), .vld(rx_vld)
  );

  for (genvar p = 0; p < LINES; p++) begin : g_line
    assign tx_oe[p]     = tx_act & (tx_line == 1'(p));
    assign tx_dat[p]    = tx_oe[p] & tx_dout;
    assign tx_slot_n[p] = ~(tx_oe[p] & ~tx_half);
  end
endmodule

// File: rtl/pcm_tdm_port_chk.sv
`timescale 1ns/1ps
module pcm_tdm_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pdn,
  input logic [1:0] tx_oe,
  input logic [1:0] tx_slot_n,
  input logic       rx_vld,
  input logic       rx_act,
  input logic       fsx_mark,
  input logic       fsr_mark
);
  AST_OE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_oe)); // R6
  AST_PDN_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |=> (tx_oe == 2'b00)); // R12
  AST_DRV_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|tx_oe) |-> (tx_slot_n != 2'b11)); // R8
  AST_DRV_ONLY_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_slot_n != 2'b11) |-> (|tx_oe)); // R8
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |=> !rx_vld); // R10
  AST_VLD_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |-> $past(rx_act)); // R10
  AST_FSX_SINGLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    fsx_mark |=> !fsx_mark); // R11
  AST_FSR_SINGLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    fsr_mark |=> !fsr_mark); // R11
endmodule

bind pcm_tdm_port pcm_tdm_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pdn(pdn), .tx_oe(tx_oe), .tx_slot_n(tx_slot_n),
  .rx_vld(rx_vld), .rx_act(rx_act), .fsx_mark(fsx_mark), .fsr_mark(fsr_mark)
);

// File: tb/tb_pcm_tdm_port.sv
`timescale 1ns/1ps
module tb_pcm_tdm_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pdn = 1'b1;
  logic       dly = 1'b0;
  logic [7:0] txc = 8'h00, rxc = 8'h00, txb = 8'h00;
  logic       fsx = 1'b0, fsr = 1'b0;
  logic [1:0] din = 2'b00;
  logic [1:0] tx_dat, tx_oe, tx_slot_n;
  logic [7:0] rx_byte;
  logic       rx_vld;

  int n_chk = 0;
  int n_bad = 0;
  int upcnt = 0;

  always #2.5 clk = ~clk;

  pcm_tdm_port dut (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .dly_mode(dly), .tx_cfg(txc),
    .rx_cfg(rxc), .fsx(fsx), .fsr(fsr), .tx_byte(txb), .rx_din(din),
    .tx_dat(tx_dat), .tx_oe(tx_oe), .tx_slot_n(tx_slot_n),
    .rx_byte(rx_byte), .rx_vld(rx_vld)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Frame bit where a slot opens, restated from R3/R4
  function automatic int open_bit(bit counted, logic [7:0] cfg);
    if (!counted) return 0;
    return (int'(cfg[5]) * 32 + int'(cfg[4]) * 16 + int'(cfg[3]) * 8 +
            int'(cfg[2]) * 4 + int'(cfg[1]) * 2 + int'(cfg[0])) * 8;
  endfunction

  task automatic run_frame(string tag, bit d, logic [7:0] tc, logic [7:0] rc,
                           logic [7:0] tbyte, logic [7:0] rbyte, bit pd,
                           int k, int wx, int wr, int pdn_at);
    int  t, r, nmax, fx, fr, j;
    bit  ready, txon, rxv;
    logic [1:0] e_oe, e_dat, e_sn;
    t = open_bit(d, tc);
    r = open_bit(d, rc);
    if (pd) upcnt = 0;
    else if (upcnt < 2) upcnt++;
    ready = !pd && (upcnt == 2);
    nmax = (t + 10 > k + r + 12) ? t + 10 : k + r + 12;
    for (int n = 0; n <= nmax; n++) begin
      @(posedge clk); #1;
      fx   = n - 1;
      j    = fx - t;
      txon = ready && tc[7] && fx >= t && fx < t + 8 && (pdn_at < 0 || n <= pdn_at);
      e_oe = txon ? (2'b01 << tc[6]) : 2'b00;
      chk(tx_slot_n == ~e_oe, {tag, "/R8 early half"}, tx_slot_n, ~e_oe);
      if (n == 0) begin dly = d; txc = tc; pdn = pd; end
      if (n == k) rxc = rc;
      if (pdn_at >= 0 && n == pdn_at) pdn = 1'b1;
      fsx = (n < wx);
      fsr = (n >= k && n < k + wr);
      txb = (n <= t) ? tbyte : 8'($urandom);
      din = 2'($urandom);
      fr  = n - 1 - k;
      if (fr >= r && fr < r + 8) din[rc[6]] = rbyte[7 - (fr - r)];
      #2;
      e_dat = txon ? ({1'b0, tbyte[7 - j]} << tc[6]) : 2'b00;
      e_sn  = (txon && j < 7) ? ~e_oe : 2'b11;
      chk(tx_oe == e_oe, {tag, "/R6 oe"}, tx_oe, e_oe);
      chk(tx_dat == e_dat, {tag, "/R7 data"}, tx_dat, e_dat);
      chk(tx_slot_n == e_sn, {tag, "/R8 late half"}, tx_slot_n, e_sn);
      rxv = !pd && rc[7] && pdn_at < 0 && fr == r + 8;
      chk(rx_vld == rxv, {tag, "/R10 strobe"}, rx_vld, rxv);
      if (rxv) chk(rx_byte == rbyte, {tag, "/R9 byte"}, rx_byte, rbyte);
    end
    if (pdn_at >= 0) upcnt = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #3;
    chk(tx_oe == 2'b00 && tx_dat == 2'b00, "R1 reset tx", {tx_oe, tx_dat}, 0);
    chk(tx_slot_n == 2'b11, "R1 reset drv", tx_slot_n, 2'b11);
    chk(rx_vld == 1'b0, "R1 reset vld", rx_vld, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #3;
    chk(tx_oe == 2'b00 && tx_slot_n == 2'b11 && rx_vld == 1'b0, "R1 after reset",
        {tx_oe, tx_slot_n, rx_vld}, 6);
    // powered down: nothing moves
    run_frame("R1", 0, 8'h80, 8'h80, 8'hA5, 8'h3C, 1, 0, 1, 1, -1);
    // power-up wait, immediate mode with nonzero slot fields ignored
    run_frame("R2", 0, 8'h85, 8'hC9, 8'h96, 8'h5A, 0, 0, 1, 1, -1);
    run_frame("R3", 0, 8'h85, 8'hC9, 8'h96, 8'hE1, 0, 1, 1, 1, -1);
    run_frame("R3", 0, 8'hFF, 8'hBF, 8'h01, 8'h80, 0, 2, 2, 1, -1);
    // counted mode corners
    run_frame("R4", 1, 8'h80, 8'h80, 8'hC3, 8'h7E, 0, 0, 1, 1, -1);
    run_frame("R4", 1, 8'hFF, 8'hE1, 8'h81, 8'h18, 0, 1, 1, 1, -1);
    run_frame("R4", 1, 8'hA0, 8'h9F, 8'h6D, 8'hB2, 0, 3, 1, 2, -1);
    // disabled directions
    run_frame("R5", 1, 8'h03, 8'h42, 8'hFF, 8'hFF, 0, 0, 1, 1, -1);
    // long syncs and skew
    run_frame("R11", 1, 8'h82, 8'hC1, 8'h3A, 8'hC5, 0, 3, 4, 4, -1);
    run_frame("R11", 0, 8'hC0, 8'h80, 8'h55, 8'hAA, 0, 2, 3, 4, -1);
    // power-down in the middle of both slots, then the wait again
    run_frame("R12", 0, 8'h80, 8'hC0, 8'hF0, 8'h0F, 0, 0, 1, 1, 4);
    run_frame("R12", 0, 8'h80, 8'h80, 8'h12, 8'h34, 0, 0, 1, 1, -1);
    run_frame("R2", 0, 8'hC0, 8'h80, 8'h9C, 8'h43, 0, 1, 1, 1, -1);
    for (int i = 0; i < 30; i++) begin
      bit d;
      logic [7:0] tc, rc;
      d  = 1'($urandom);
      tc = 8'($urandom) | 8'h80;
      rc = 8'($urandom);
      if ((i % 4) != 0) rc[7] = 1'b1;
      if (d && (i % 3) != 0) begin tc[5:4] = 2'b00; rc[5:4] = 2'b00; end
      run_frame(d ? "R4" : "R3", d, tc, rc, 8'($urandom), 8'($urandom), 0,
                int'($urandom_range(0, 3)), int'($urandom_range(1, 4)),
                int'($urandom_range(1, 4)), -1);
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule